// File: doc/BRIEF.md
# Oscillator Watchdog Clock Switcher

This block supervises the crystal clock while the PLL is bypassed. A free-running reference clock samples the crystal waveform through a two-flop synchroniser. Every crystal transition restarts a timeout counter. If the counter reaches a limit that spans at least one microsecond of reference time, the block marks a fallback. The CPU clock select then moves to the PLL base clock, which runs at 2 to 10 MHz. The fallback is sticky: the flag and the PLL selection stay set until reset.

Monitoring is active only when the PLL bypass strap is high and the watchdog-disable bit is low. When the PLL is not bypassed, the CPU runs from the PLL and the detector stays idle. When the PLL is bypassed with the watchdog disabled, the CPU always runs from the crystal, and the PLL power enable is dropped to save supply current. The analog PLL, the glitch-free clock mux and the oscillator itself are outside this block. It drives only their control inputs.

Top module: `osc_wdog_clksel`

## Requirements
- R1: After reset with bypass=1 and disable=0, fallback_o=0, sel_pll_o=0 (0 selects the crystal, 1 selects the PLL base clock) and pll_pwr_en_o=1.
- R2: The timeout limit is T = ceil(REF_KHZ/1000) reference cycles, which is at least 1 us. With the default REF_KHZ=10000, T=10.
- R3: In monitored mode (bypass=1, disable=0), after the last crystal transition fallback_o is still 0 after T+3 reference rising edges and is 1 after T+4.
- R4: In monitored mode, a crystal that holds each level for k reference cycles never causes a fallback when k<=T. When k>=T+1 it does cause one.
- R5: With bypass=1 and disable=1, sel_pll_o=0 and pll_pwr_en_o=0, and no fallback occurs however long the crystal is static.
- R6: With bypass=0, sel_pll_o=1 and pll_pwr_en_o=1, and no fallback occurs with a static crystal.
- R7: On entering monitored mode with a static crystal, the count starts from zero. fallback_o is 0 after T reference edges and 1 after T+1.
- R8: Once fallback_o=1, fallback_o, sel_pll_o and pll_pwr_en_o all stay 1 until reset, whatever the crystal activity or mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock for timing |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xtal_i | input | 1 | Crystal clock, sampled as data |
| pll_bypass_i | input | 1 | Strap: 1 means the PLL is bypassed |
| wdog_dis_i | input | 1 | 1 disables the oscillator watchdog |
| sel_pll_o | output | 1 | CPU clock select: 1 for PLL base clock, 0 for crystal |
| pll_pwr_en_o | output | 1 | PLL power enable |
| fallback_o | output | 1 | Sticky flag: a crystal-loss fallback happened |

## Verification
The assertions assume the strap and disable inputs are static relative to the reference clock. They also assume the crystal is slow enough relative to the reference clock that the synchroniser sees every level. The bench therefore changes all inputs on falling reference edges. It drives the crystal as a waveform whose half-period is a whole number of reference cycles, sweeping that half-period from 1 to T+3. Mode changes are applied only when the crystal is static, so the counts after a transition are exact.

// File: rtl/osc_wdog_pkg.sv
package osc_wdog_pkg;
  // reference cycles covering at least 1 us
  function automatic int unsigned tmo_cycles(input int unsigned ref_khz);
    return (ref_khz + 999) / 1000;
  endfunction
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], xtal_i};
  end

  // any transition past the synchroniser
  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/osc_tmo_cnt.sv
module osc_tmo_cnt #(
  parameter int unsigned TMO   = 10,
  parameter int unsigned CNT_W = $clog2(TMO + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TMO);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q != TMO_C) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == TMO_C);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TMO_C);
  // R4
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !expired_o);
endmodule

// File: rtl/osc_sel_ctrl.sv
module osc_sel_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic dis_i,
  input  logic expired_i,
  output logic mon_en_o,
  output logic fallback_o,
  output logic sel_pll_o,
  output logic pwr_en_o
);
  logic fb_q;

  assign mon_en_o = bypass_i & ~dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fb_q <= 1'b0;
    else if (mon_en_o && expired_i) fb_q <= 1'b1;
  end

  assign fallback_o = fb_q;
  assign sel_pll_o  = ~bypass_i | fb_q;
  // PLL off only when crystal is the permanent source
  assign pwr_en_o   = ~(bypass_i & dis_i) | fb_q;

  // R8
  fb_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_q |=> fb_q);
  // R5
  no_fb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mon_en_o && !fb_q) |=> !fb_q);
endmodule

// File: rtl/osc_wdog_clksel.sv
module osc_wdog_clksel #(
  parameter int unsigned REF_KHZ     = 10000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref_i,
  input  logic rst_ni,
  input  logic xtal_i,
  input  logic pll_bypass_i,
  input  logic wdog_dis_i,
  output logic sel_pll_o,
  output logic pll_pwr_en_o,
  output logic fallback_o
);
  import osc_wdog_pkg::*;

  localparam int unsigned TMO   = tmo_cycles(REF_KHZ);
  localparam int unsigned CNT_W = $clog2(TMO + 1);

  logic xedge, expired, mon_en;

  osc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .xtal_i (xtal_i),
    .edge_o (xedge)
  );

  osc_tmo_cnt #(.TMO(TMO), .CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_ref_i),
    .rst_ni    (rst_ni),
    .clear_i   (~mon_en | xedge),
    .expired_o (expired)
  );

  osc_sel_ctrl i_ctrl (
    .clk_i      (clk_ref_i),
    .rst_ni     (rst_ni),
    .bypass_i   (pll_bypass_i),
    .dis_i      (wdog_dis_i),
    .expired_i  (expired),
    .mon_en_o   (mon_en),
    .fallback_o (fallback_o),
    .sel_pll_o  (sel_pll_o),
    .pwr_en_o   (pll_pwr_en_o)
  );

  // R3
  fb_cause_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    $rose(fallback_o) |-> $past(expired && mon_en));
  // R5
  pwr_sel_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    !pll_pwr_en_o |-> !sel_pll_o);
  // R6
  pll_mode_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    !pll_bypass_i |-> (sel_pll_o && pll_pwr_en_o));
endmodule

// File: tb/test_osc_wdog_clksel.sv
module test_osc_wdog_clksel;
  localparam int CLK_PERIOD = 10;
  localparam int REF_KHZ    = 10000;
  localparam int T          = (REF_KHZ + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0, xtal = 1'b0, byp = 1'b1, dis = 1'b0;
  logic sel, pwr, fb;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_wdog_clksel #(.REF_KHZ(REF_KHZ)) i_osc_wdog_clksel (
    .clk_ref_i(clk), .rst_ni(rst_n), .xtal_i(xtal),
    .pll_bypass_i(byp), .wdog_dis_i(dis),
    .sel_pll_o(sel), .pll_pwr_en_o(pwr), .fallback_o(fb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic b, input logic d);
    @(negedge clk);
    rst_n = 1'b0; xtal = 1'b0; byp = b; dis = d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b1, 1'b0);
    chk("R1 fallback", fb, 1'b0);
    chk("R1 sel", sel, 1'b0);
    chk("R1 pwr", pwr, 1'b1);

    // R2/R3 exact timeout from last crystal transition
    xtal = 1'b1;
    repeat (T + 3) @(negedge clk);
    chk("R3 before limit", fb, 1'b0);
    chk("R2 T value", (T == 10), 1'b1);
    @(negedge clk);
    chk("R3 at limit", fb, 1'b1);
    chk("R3 sel pll", sel, 1'b1);

    // R4 sweep of crystal half-period
    for (int k = 1; k <= T + 3; k++) begin
      do_reset(1'b1, 1'b0);
      for (int n = 0; n < 4 * (T + 3) / k + 4; n++) begin
        xtal = ~xtal;
        repeat (k) @(negedge clk);
      end
      chk($sformatf("R4 half-period %0d", k), fb, (k >= T + 1));
    end

    // R5 disabled in bypass
    do_reset(1'b1, 1'b1);
    repeat (5 * T) @(negedge clk);
    chk("R5 fallback", fb, 1'b0);
    chk("R5 sel", sel, 1'b0);
    chk("R5 pwr", pwr, 1'b0);

    // R6 PLL mode, then R7 restart on entering monitored mode
    do_reset(1'b0, 1'b0);
    repeat (5 * T) @(negedge clk);
    chk("R6 fallback", fb, 1'b0);
    chk("R6 sel", sel, 1'b1);
    chk("R6 pwr", pwr, 1'b1);
    byp = 1'b1;
    repeat (T) @(negedge clk);
    chk("R7 before limit", fb, 1'b0);
    chk("R7 sel crystal", sel, 1'b0);
    @(negedge clk);
    chk("R7 at limit", fb, 1'b1);

    // R8 sticky after fallback
    for (int n = 0; n < 20; n++) begin
      xtal = ~xtal;
      @(negedge clk);
    end
    dis = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 fallback", fb, 1'b1);
    chk("R8 sel", sel, 1'b1);
    chk("R8 pwr", pwr, 1'b1);
    byp = 1'b0;
    @(negedge clk);
    chk("R8 fallback pll mode", fb, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule